// File: doc/BRIEF.md
# Sixteen-Bit Reload Timer with Multi-Role Event Input

This block is a 16-bit down-counter with a reload value and a single external input, TI. The count can advance on a divided internal clock, at half, one eighth or one thirty-second of the block clock. It can also advance on edges seen on TI. When running from the internal clock, TI can serve three purposes: it can be ignored, it can act as a start trigger on a chosen edge, or it can act as a count gate with a chosen active level.

Underflow happens when a count step arrives while the counter is at zero. On underflow the counter reloads and the interrupt flag is set. A one-clock strobe is also driven out, so that a neighbouring converter can start a conversion. What happens next depends on the mode. In reload mode the timer output toggles and counting goes on. In one-shot mode the counter stops until the next software or TI trigger, and the timer output is high exactly while the counter runs.

Configuration arrives as plain input ports, driven by whatever register file sits around the block. The TI pin passes through a two-flop synchroniser followed by an edge-detect flop. A TI level therefore has to be held for at least two clocks to be seen reliably.

Top module: `reload_timer16`

## Requirements
- R1: After reset, count is 0 and tout, irq_flag and conv_trig are all 0.
- R2: With cnt_en high, a clock edge with sw_trig high loads count from reload_val and starts counting, with the prescaler phase restarted. With cnt_en low, counting stops, count holds, and sw_trig and TI triggers have no effect.
- R3: In internal-clock mode, src_sel 0, 1 and 2 give one count step every 2, 8 and 32 clocks respectively. In reload mode, successive conv_trig pulses are therefore (reload_val+1)*divisor clocks apart.
- R4: With src_sel 3 (event mode), count steps once per synchronised TI edge of the selected kind: ti_cfg 1 selects rising edges, 2 selects falling edges and 3 selects both. ti_cfg 0 gives no steps.
- R5: In internal-clock mode, ti_cfg 1 (rising edge) or ti_cfg 2 (falling edge) makes the selected TI edge start the counter, just as sw_trig does.
- R6: In internal-clock mode with ti_cfg 3, the prescaler and the counter advance only while the synchronised TI equals gate_level.
- R7: In reload mode (reload_mode=1), underflow loads reload_val into count and toggles tout.
- R8: In one-shot mode (reload_mode=0), underflow loads reload_val into count and stops the counter. In this mode tout is high exactly while the counter runs.
- R9: irq_flag is set on underflow and stays set until a clock edge with irq_clr high and no new underflow. Set wins over clear.
- R10: conv_trig is high for one clock after each underflow edge, at the same edge that sets irq_flag.
- R11: In internal-clock mode with ti_cfg 0, TI changes neither count nor tout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable; low stops and disarms the timer |
| sw_trig | input | 1 | Software start: load and run |
| reload_mode | input | 1 | 1 = reload on underflow, 0 = one-shot |
| src_sel | input | 2 | 0: clk/2, 1: clk/8, 2: clk/32, 3: TI event count |
| ti_cfg | input | 2 | TI role: 0 none, 1 rising, 2 falling, 3 gate (both edges in event mode) |
| gate_level | input | 1 | Active TI level when gating |
| reload_val | input | 16 | Reload value |
| irq_clr | input | 1 | Clears irq_flag |
| ti | input | 1 | External timer input, asynchronous |
| count | output | 16 | Current counter value |
| tout | output | 1 | Timer output (toggle in reload mode, run level in one-shot mode) |
| irq_flag | output | 1 | Sticky underflow flag |
| conv_trig | output | 1 | One-clock underflow strobe for a converter |

## Verification
The bench measures the distance between underflow strobes for each divisor. A prescaler that is off by one, or that is not restarted on a trigger, shows up as a wrong period. It also drives counted TI pulses in event mode under each edge selection: a design that decodes the edge field wrongly loses steps or counts extra ones. Directed sequences cover the stopped one-shot state, where stray TI toggles with no TI role must not restart the timer while a correct edge does. They also cover a closed gate, where the count must freeze rather than drift, and a disabled timer, where a software trigger must not reload. Long random runs over all modes are compared each cycle against a bench model, which catches wrong priority between start, clear and underflow.

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int CW      = 16,
  parameter int DIV0_LG = 1,
  parameter int DIV1_LG = 3,
  parameter int DIV2_LG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          sw_trig,
  input  logic          reload_mode,
  input  logic [1:0]    src_sel,
  input  logic [1:0]    ti_cfg,
  input  logic          gate_level,
  input  logic [CW-1:0] reload_val,
  input  logic          irq_clr,
  input  logic          ti,
  output logic [CW-1:0] count,
  output logic          tout,
  output logic          irq_flag,
  output logic          conv_trig
);
  localparam int PSW = DIV2_LG;

  logic [2:0]     ti_sync;
  logic [PSW-1:0] psc;
  logic [PSW-1:0] div_mask;
  logic           running;
  logic           tog;

  wire ti_lvl     = ti_sync[1];
  wire ti_rise    = ti_sync[1] & ~ti_sync[2];
  wire ti_fall    = ~ti_sync[1] & ti_sync[2];
  wire event_mode = (src_sel == 2'd3);
  wire edge_hit   = (ti_cfg[0] & ti_rise) | (ti_cfg[1] & ti_fall);
  wire ext_start  = !event_mode &&
                    (((ti_cfg == 2'd1) && ti_rise) || ((ti_cfg == 2'd2) && ti_fall));
  wire gate_ok    = event_mode || (ti_cfg != 2'd3) || (ti_lvl == gate_level);
  wire start      = cnt_en && (sw_trig || ext_start);
  wire psc_hit    = ((psc & div_mask) == div_mask);
  wire tick       = running && (event_mode ? edge_hit : (gate_ok && psc_hit));
  wire underflow  = cnt_en && !start && tick && (count == '0);

  always_comb begin
    case (src_sel)
      2'd0:    div_mask = {PSW{1'b1}} >> (PSW - DIV0_LG);
      2'd1:    div_mask = {PSW{1'b1}} >> (PSW - DIV1_LG);
      default: div_mask = {PSW{1'b1}} >> (PSW - DIV2_LG);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti_sync   <= '0;
      psc       <= '0;
      running   <= 1'b0;
      count     <= '0;
      tog       <= 1'b0;
      irq_flag  <= 1'b0;
      conv_trig <= 1'b0;
    end else begin
      ti_sync   <= {ti_sync[1:0], ti};
      conv_trig <= underflow;
      if (underflow)    irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;

      if (!cnt_en) begin
        running <= 1'b0;
        psc     <= '0;
      end else if (start) begin
        count   <= reload_val;
        running <= 1'b1;
        psc     <= '0;
      end else if (running) begin
        if (!event_mode && gate_ok) psc <= psc + 1'b1;
        if (tick) begin
          if (count == '0) begin
            count <= reload_val;
            if (reload_mode) tog <= ~tog;
            else             running <= 1'b0;
          end else begin
            count <= count - 1'b1;
          end
        end
      end
    end
  end

  assign tout = reload_mode ? tog : running;
endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          reload_mode,
  input logic [CW-1:0] reload_val,
  input logic          irq_clr,
  input logic [CW-1:0] count,
  input logic          tout,
  input logic          irq_flag,
  input logic          conv_trig,
  input logic          running,
  input logic          start
);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R10
  conv_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig |-> irq_flag);

  // R7
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_trig && $stable(reload_val)) |-> (count == reload_val));

  // R7
  tout_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_trig && reload_mode && $past(reload_mode)) |-> (tout != $past(tout)));

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_trig && !$past(reload_mode)) |-> !running);

  // R2
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> !running);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));
endmodule

bind reload_timer16 reload_timer16_chk #(.CW(CW)) u_chk (.*);

// File: tb/reload_timer16_bench.sv
`timescale 1ns/1ps
module reload_timer16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, sw_trig = 1'b0, reload_mode = 1'b1;
  logic [1:0]  src_sel = 2'd0, ti_cfg = 2'd0;
  logic        gate_level = 1'b1, irq_clr = 1'b0, ti = 1'b0;
  logic [15:0] reload_val = 16'd0;
  logic [15:0] count;
  logic        tout, irq_flag, conv_trig;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  reload_timer16 u_reload_timer16 (
    .clk, .rst_n, .cnt_en, .sw_trig, .reload_mode, .src_sel, .ti_cfg,
    .gate_level, .reload_val, .irq_clr, .ti, .count, .tout, .irq_flag, .conv_trig
  );

  // Bench reference state, advanced once per rising edge from the requirements
  bit h0, h1, h2, m_run, m_tog, m_irq, m_conv;
  int m_cnt, m_ph;

  always @(posedge clk) begin : ref_step
    bit r, f, ev, hit, ext, gopen, adv, uf;
    int div;
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; m_run = 0; m_tog = 0; m_irq = 0; m_conv = 0;
      m_cnt = 0; m_ph = 0;
    end else begin
      r = h1 && !h2;
      f = !h1 && h2;
      ev = (src_sel == 2'd3);
      hit = ((ti_cfg == 2'd1 || ti_cfg == 2'd3) && r) || ((ti_cfg == 2'd2 || ti_cfg == 2'd3) && f);
      ext = !ev && ((ti_cfg == 2'd1 && r) || (ti_cfg == 2'd2 && f));
      gopen = ev || ti_cfg != 2'd3 || (h1 == gate_level);
      div = (src_sel == 2'd0) ? 2 : (src_sel == 2'd1) ? 8 : 32;
      uf = 0;
      if (!cnt_en) begin
        m_run = 0; m_ph = 0;
      end else if (sw_trig || ext) begin
        m_cnt = reload_val; m_run = 1; m_ph = 0;
      end else if (m_run) begin
        adv = 0;
        if (ev) adv = hit;
        else if (gopen) begin
          m_ph = m_ph + 1;
          if (m_ph == div) begin m_ph = 0; adv = 1; end
        end
        if (adv) begin
          if (m_cnt == 0) begin
            m_cnt = reload_val; uf = 1;
            if (reload_mode) m_tog = !m_tog; else m_run = 0;
          end else m_cnt = m_cnt - 1;
        end
      end
      if (uf) m_irq = 1; else if (irq_clr) m_irq = 0;
      m_conv = uf;
      h2 = h1; h1 = h0; h0 = ti;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R4/R7 model count", int'(count), m_cnt);
    chk("R8 model tout", int'(tout), reload_mode ? int'(m_tog) : int'(m_run));
    chk("R9 model irq_flag", int'(irq_flag), int'(m_irq));
    chk("R10 model conv_trig", int'(conv_trig), int'(m_conv));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    cnt_en = 1'b1; sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic wait_conv(input int limit);
    int n = 0;
    while (!conv_trig && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_ti();
    ti = 1'b1; cyc(3);
    ti = 1'b0; cyc(3);
  endtask

  task automatic period_test(input logic [1:0] src, input int rel, input int exp, input string tag);
    int p;
    logic tg0;
    cnt_en = 1'b0; @(negedge clk);
    src_sel = src; reload_val = 16'(rel); reload_mode = 1'b1; ti_cfg = 2'd0;
    kick();
    wait_conv(400);
    tg0 = tout;
    @(negedge clk);
    chk("R10 strobe width", int'(conv_trig), 0);
    p = 1;
    while (!conv_trig && p < 400) begin @(negedge clk); p++; end
    chk(tag, p, exp);
    chk("R7 tout toggles", int'(tout), int'(!tg0));
  endtask

  initial begin : watchdog
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int v;
    void'($urandom(32'd20240607));
    cyc(3);
    // R1
    chk("R1 count", int'(count), 0);
    chk("R1 tout", int'(tout), 0);
    chk("R1 irq_flag", int'(irq_flag), 0);
    chk("R1 conv_trig", int'(conv_trig), 0);
    rst_n = 1'b1;
    cyc(2);

    // R3 periods per divisor
    period_test(2'd0, 3, 8,  "R3 div2 period");
    period_test(2'd1, 2, 24, "R3 div8 period");
    period_test(2'd2, 1, 64, "R3 div32 period");
    period_test(2'd0, 0, 2,  "R3 div2 reload0 period");

    // R2 load and disable
    cnt_en = 1'b0; @(negedge clk);
    reload_val = 16'd7; src_sel = 2'd1; reload_mode = 1'b1; ti_cfg = 2'd0;
    kick();
    chk("R2 load on sw_trig", int'(count), 7);
    cyc(20);
    cnt_en = 1'b0; @(negedge clk);
    v = int'(count);
    reload_val = 16'd99; sw_trig = 1'b1;
    cyc(50);
    sw_trig = 1'b0;
    chk("R2 disabled hold", int'(count), v);

    // R4 event counting
    cnt_en = 1'b0; @(negedge clk);
    src_sel = 2'd3; ti_cfg = 2'd1; reload_val = 16'd10; ti = 1'b0;
    cyc(4);
    kick();
    repeat (4) pulse_ti();
    cyc(5);
    chk("R4 rising edges", int'(count), 6);
    ti_cfg = 2'd3;
    repeat (2) pulse_ti();
    cyc(5);
    chk("R4 both edges", int'(count), 2);
    ti_cfg = 2'd2;
    pulse_ti();
    cyc(5);
    chk("R4 falling edges", int'(count), 1);
    ti_cfg = 2'd0;
    repeat (2) pulse_ti();
    cyc(5);
    chk("R4 no edge role", int'(count), 1);

    // R8, R9, R11, R5 one-shot sequence
    cnt_en = 1'b0; @(negedge clk);
    src_sel = 2'd0; ti_cfg = 2'd0; reload_mode = 1'b0; reload_val = 16'd5; ti = 1'b0;
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    kick();
    chk("R8 tout high while running", int'(tout), 1);
    wait_conv(100);
    chk("R8 reload after underflow", int'(count), 5);
    chk("R8 tout low after stop", int'(tout), 0);
    chk("R9 irq set", int'(irq_flag), 1);
    cyc(10);
    chk("R9 irq held", int'(irq_flag), 1);
    chk("R8 stopped count", int'(count), 5);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R9 irq cleared", int'(irq_flag), 0);
    repeat (3) pulse_ti();
    cyc(10);
    chk("R11 ignored TI count", int'(count), 5);
    chk("R11 ignored TI tout", int'(tout), 0);
    ti_cfg = 2'd1; @(negedge clk);
    ti = 1'b1; cyc(5);
    chk("R5 rising start", int'(tout), 1);
    wait_conv(100);
    cyc(2);
    chk("R5 one-shot done", int'(tout), 0);
    ti_cfg = 2'd2; @(negedge clk);
    ti = 1'b0; cyc(5);
    chk("R5 falling start", int'(tout), 1);
    wait_conv(100);
    cyc(2);

    // R6 gating
    cnt_en = 1'b0; @(negedge clk);
    src_sel = 2'd0; ti_cfg = 2'd3; gate_level = 1'b1; reload_mode = 1'b1;
    reload_val = 16'd100; ti = 1'b0;
    cyc(4);
    kick();
    cyc(40);
    chk("R6 gate closed", int'(count), 100);
    ti = 1'b1; cyc(20);
    chk("R6 gate open counts", int'(count < 16'd100 && count > 16'd85), 1);
    ti = 1'b0; cyc(5);
    v = int'(count);
    cyc(40);
    chk("R6 gate reclosed", int'(count), v);
    gate_level = 1'b0; cyc(10);
    chk("R6 low active level", int'(count < 16'(v)), 1);

    // Random phase against the bench model
    for (int s = 0; s < 30; s++) begin
      cnt_en = 1'b0; sw_trig = 1'b0; @(negedge clk);
      src_sel = 2'($urandom % 4); ti_cfg = 2'($urandom % 4);
      gate_level = 1'($urandom % 2); reload_mode = 1'($urandom % 2);
      reload_val = 16'($urandom % 24);
      cnt_en = 1'b1;
      for (int c = 0; c < 250; c++) begin
        sw_trig = ($urandom % 50) == 0;
        irq_clr = ($urandom % 12) == 0;
        if (($urandom % 4) == 0) ti = ~ti;
        @(negedge clk);
        cmp_model();
      end
    end
    sw_trig = 1'b0; irq_clr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule